// File: doc/BRIEF.md
# Dual-Bank Crossbar Routing Controller

This block holds the control logic for a bidirectional two-bank, four-port switch. Bank A and bank B can each connect to one of the ports SW0 to SW3. Every bank carries five channels, and all five channels of a bank follow one connect decision. The block produces one connect vector per bank. Bit n of that vector closes all five channels of the bank onto port SWn. The analog switch cells and the serial register engine sit outside this block.

A mode input picks where the routing request comes from. In pin mode, six bidirectional control pins act as inputs and carry an enable and a 2-bit port select for each bank. In serial mode, the same request comes from enable and select fields that an external register engine supplies. In that mode four of the control pins become tri-state data outputs fed from that engine, and the other two pins are not driven.

The connect vectors are registered. Every change of route is break-before-make: the old connection opens one cycle before the new one closes. A bank also never closes a port that the other bank still holds. When both banks ask for the same port, bank A gets it.

Top module: `xr_route_ctrl`

## Requirements
- R1: With `mode_i`=0, the routing request comes from `pin_i`. Bank A's select is `pin_i[1:0]` and its enable is `pin_i[2]`. Bank B's select is `pin_i[4:3]` and its enable is `pin_i[5]`.
- R2: With `mode_i`=1, the routing request comes from `cfg_a_en_i`, `cfg_a_sel_i`, `cfg_b_en_i` and `cfg_b_sel_i`. The value of `pin_i` has no effect on either connect vector.
- R3: A bank whose enable is 0 requests no port, and its connect vector becomes 4'b0000.
- R4: An enabled bank with select value n (0 to 3) requests port SWn. Its connect vector settles to the one-hot value with only bit n set.
- R5: When both banks are enabled and select the same port, bank A requests that port and bank B requests none. When bank A is disabled, bank B may use any port.
- R6: Connect vectors are registered. A change from no connection to a port appears one clock after the request is sampled. A change from one port to a different port first shows 4'b0000 for one cycle, and the new port closes on the next cycle.
- R7: The two connect vectors never share a set bit. A bank whose requested port is still held by the other bank stays at 4'b0000 until that port is released.
- R8: With `mode_i`=0, `pin_oe_o` is 6'b000000 and `pin_do_o` is 6'b000000.
- R9: With `mode_i`=1, for bits 0 to 3, `pin_oe_o[i]` equals the inverse of `cfg_do_hiz_i[i]` and `pin_do_o[i]` equals `cfg_do_val_i[i]`. Bits 4 and 5 of `pin_oe_o` are 0. The pin outputs follow the mode and the configuration inputs without a clock delay.
- R10: While `rst_n` is 0 at a clock edge, both connect vectors are cleared to 4'b0000. They stay 4'b0000 until the first request sampled after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 = pin control, 1 = serial register control |
| pin_i | input | 6 | Input value of the six control pins |
| cfg_a_en_i | input | 1 | Register enable field for bank A |
| cfg_a_sel_i | input | 2 | Register port select field for bank A |
| cfg_b_en_i | input | 1 | Register enable field for bank B |
| cfg_b_sel_i | input | 2 | Register port select field for bank B |
| cfg_do_val_i | input | 4 | Drive data for control pins 0 to 3 in serial mode |
| cfg_do_hiz_i | input | 4 | High-impedance request for control pins 0 to 3 in serial mode |
| pin_oe_o | output | 6 | Output enable per control pin |
| pin_do_o | output | 6 | Drive value per control pin |
| conn_a_o | output | 4 | One-hot connect vector for bank A, bit n closes onto SWn |
| conn_b_o | output | 4 | One-hot connect vector for bank B, bit n closes onto SWn |

## Verification
The bench builds the block with its default parameters: four ports, a 2-bit select and four serial data pins. With only four ports, random selects collide often. Random traffic therefore reaches the same-port priority, the wait on a port the other bank still holds, and port-to-port moves through the one-cycle open state many times per run. The default width also lets directed cases cover every select value and every mode switch.

// File: rtl/xr_pkg.sv
// Package xr_pkg: shared defaults and the mode encoding for the crossbar
// routing controller. Assumes a port count of at least two.
package xr_pkg;
    localparam int unsigned XR_NUM_PORTS = 4;
    localparam int unsigned XR_DO_W      = 4;

    typedef enum logic {
        XR_MODE_PINS   = 1'b0,
        XR_MODE_SERIAL = 1'b1
    } xr_mode_e;
endpackage

// File: rtl/xr_src_mux.sv
// xr_src_mux: chooses the routing request source. In pin mode the request
// comes from the control pins; in serial mode it comes from the register
// fields. Pin layout: per bank, SEL_W select bits then one enable bit, with
// bank A in the low half. Purely combinational.
module xr_src_mux #(
    parameter int unsigned SEL_W = 2,
    localparam int unsigned PIN_W = 2 * (SEL_W + 1)
) (
    input  logic             mode_i,
    input  logic [PIN_W-1:0] pin_i,
    input  logic             cfg_a_en_i,
    input  logic [SEL_W-1:0] cfg_a_sel_i,
    input  logic             cfg_b_en_i,
    input  logic [SEL_W-1:0] cfg_b_sel_i,
    output logic             a_en_o,
    output logic [SEL_W-1:0] a_sel_o,
    output logic             b_en_o,
    output logic [SEL_W-1:0] b_sel_o
);
    import xr_pkg::*;

    // Select the request fields according to the mode input.
    always_comb begin
        if (xr_mode_e'(mode_i) == XR_MODE_SERIAL) begin
            a_en_o  = cfg_a_en_i;
            a_sel_o = cfg_a_sel_i;
            b_en_o  = cfg_b_en_i;
            b_sel_o = cfg_b_sel_i;
        end else begin
            a_sel_o = pin_i[SEL_W-1:0];
            a_en_o  = pin_i[SEL_W];
            b_sel_o = pin_i[SEL_W+1 +: SEL_W];
            b_en_o  = pin_i[PIN_W-1];
        end
    end
endmodule

// File: rtl/xr_route_decode.sv
// xr_route_decode: turns an enable and select per bank into one-hot target
// vectors. Bank A wins a port both banks request. A select at or above
// NUM_PORTS requests nothing. Combinational; clk/rst_n only feed assertions.
module xr_route_decode #(
    parameter int unsigned NUM_PORTS = 4,
    localparam int unsigned SEL_W = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_en_i,
    input  logic [SEL_W-1:0]     a_sel_i,
    input  logic                 b_en_i,
    input  logic [SEL_W-1:0]     b_sel_i,
    output logic [NUM_PORTS-1:0] tgt_a_o,
    output logic [NUM_PORTS-1:0] tgt_b_o
);
    // One decode slice per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit_a;
        logic hit_b;
        // Port p hit tests for each bank.
        always_comb begin
            hit_a = a_en_i && (a_sel_i == SEL_W'(p));
            hit_b = b_en_i && (b_sel_i == SEL_W'(p));
        end
        // Bank A has priority on a shared port.
        assign tgt_a_o[p] = hit_a;
        assign tgt_b_o[p] = hit_b && !hit_a;
    end

    // R5: the two targets never overlap.
    assert_tgt_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_a_o & tgt_b_o) == '0);
    // R3: a disabled bank requests no port.
    assert_tgt_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en_i |-> tgt_a_o == '0);
    // R4: a request names at most one port.
    assert_tgt_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_a_o) && $onehot0(tgt_b_o));
endmodule

// File: rtl/xr_bank_seq.sv
// xr_bank_seq: registered connect vector of one bank with break-before-make.
// A route that differs from the held one first opens for one cycle. A bank
// closes a new port only when the other bank's held vector does not hold it.
module xr_bank_seq #(
    parameter int unsigned NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] tgt_i,
    input  logic [NUM_PORTS-1:0] other_q_i,
    output logic [NUM_PORTS-1:0] conn_q_o
);
    logic [NUM_PORTS-1:0] conn_nxt;

    // Next-state choice: hold, open, wait for the other bank, or close.
    always_comb begin
        if (tgt_i == conn_q_o) begin
            conn_nxt = conn_q_o;
        end else if (conn_q_o != '0) begin
            conn_nxt = '0;
        end else if ((tgt_i & other_q_i) != '0) begin
            conn_nxt = '0;
        end else begin
            conn_nxt = tgt_i;
        end
    end

    // Connect register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q_o <= '0;
        end else begin
            conn_q_o <= conn_nxt;
        end
    end

    // R6: a held route either stays or opens fully; never port-to-port.
    assert_break_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_q_o != '0) |=> (conn_q_o == $past(conn_q_o)) || (conn_q_o == '0));
    // R4: at most one port closed per bank.
    assert_conn_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(conn_q_o));
endmodule

// File: rtl/xr_pin_drive.sv
// xr_pin_drive: direction and drive of the control pins. In pin mode no pin
// is driven. In serial mode the low DO_W pins drive register data unless
// their high-impedance bit is set; the rest stay undriven. Assumes DO_W <
// PIN_W. Combinational; clk/rst_n only feed assertions.
module xr_pin_drive #(
    parameter int unsigned PIN_W = 6,
    parameter int unsigned DO_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic [DO_W-1:0]  do_val_i,
    input  logic [DO_W-1:0]  do_hiz_i,
    output logic [PIN_W-1:0] pin_oe_o,
    output logic [PIN_W-1:0] pin_do_o
);
    import xr_pkg::*;

    // One slice per control pin.
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        if (i < DO_W) begin : g_data
            // Data pin: driven only in serial mode.
            always_comb begin
                if (xr_mode_e'(mode_i) == XR_MODE_SERIAL) begin
                    pin_oe_o[i] = !do_hiz_i[i];
                    pin_do_o[i] = do_val_i[i];
                end else begin
                    pin_oe_o[i] = 1'b0;
                    pin_do_o[i] = 1'b0;
                end
            end
        end else begin : g_idle
            // Input-only pin: never driven.
            assign pin_oe_o[i] = 1'b0;
            assign pin_do_o[i] = 1'b0;
        end
    end

    // R8: pin mode leaves every control pin as an input.
    assert_pins_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> (pin_oe_o == '0));
    // R9: pins above the data range are never driven.
    assert_upper_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o >> DO_W) == '0);
endmodule

// File: rtl/xr_route_ctrl.sv
// xr_route_ctrl: top of the dual-bank crossbar routing controller. Picks the
// request source by mode, decodes it to one-hot targets with bank A priority,
// sequences each bank break-before-make and drives the control pins.
// Assumes NUM_PORTS >= 2 and DO_W < PIN_W.
module xr_route_ctrl #(
    parameter int unsigned NUM_PORTS = xr_pkg::XR_NUM_PORTS,
    parameter int unsigned DO_W      = xr_pkg::XR_DO_W,
    localparam int unsigned SEL_W = $clog2(NUM_PORTS),
    localparam int unsigned PIN_W = 2 * (SEL_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic [PIN_W-1:0]     pin_i,
    input  logic                 cfg_a_en_i,
    input  logic [SEL_W-1:0]     cfg_a_sel_i,
    input  logic                 cfg_b_en_i,
    input  logic [SEL_W-1:0]     cfg_b_sel_i,
    input  logic [DO_W-1:0]      cfg_do_val_i,
    input  logic [DO_W-1:0]      cfg_do_hiz_i,
    output logic [PIN_W-1:0]     pin_oe_o,
    output logic [PIN_W-1:0]     pin_do_o,
    output logic [NUM_PORTS-1:0] conn_a_o,
    output logic [NUM_PORTS-1:0] conn_b_o
);
    logic                 a_en, b_en;
    logic [SEL_W-1:0]     a_sel, b_sel;
    logic [NUM_PORTS-1:0] tgt_a, tgt_b;

    xr_src_mux #(.SEL_W(SEL_W)) u_src (
        .mode_i     (mode_i),
        .pin_i      (pin_i),
        .cfg_a_en_i (cfg_a_en_i),
        .cfg_a_sel_i(cfg_a_sel_i),
        .cfg_b_en_i (cfg_b_en_i),
        .cfg_b_sel_i(cfg_b_sel_i),
        .a_en_o     (a_en),
        .a_sel_o    (a_sel),
        .b_en_o     (b_en),
        .b_sel_o    (b_sel)
    );

    xr_route_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_en_i (a_en),
        .a_sel_i(a_sel),
        .b_en_i (b_en),
        .b_sel_i(b_sel),
        .tgt_a_o(tgt_a),
        .tgt_b_o(tgt_b)
    );

    xr_bank_seq #(.NUM_PORTS(NUM_PORTS)) u_seq_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_i    (tgt_a),
        .other_q_i(conn_b_o),
        .conn_q_o (conn_a_o)
    );

    xr_bank_seq #(.NUM_PORTS(NUM_PORTS)) u_seq_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_i    (tgt_b),
        .other_q_i(conn_a_o),
        .conn_q_o (conn_b_o)
    );

    xr_pin_drive #(.PIN_W(PIN_W), .DO_W(DO_W)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .do_val_i(cfg_do_val_i),
        .do_hiz_i(cfg_do_hiz_i),
        .pin_oe_o(pin_oe_o),
        .pin_do_o(pin_do_o)
    );

    // R7: the banks never hold the same port.
    assert_banks_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_a_o & conn_b_o) == '0);
    // R10: the cycle after a reset edge shows both banks open.
    assert_reset_open_R10: assert property (@(posedge clk)
        !rst_n |=> (conn_a_o == '0) && (conn_b_o == '0));
endmodule

// File: tb/xr_route_ctrl_tb_top.sv
// Bench for xr_route_ctrl: directed corners plus seeded random traffic,
// checked against a reference model built from the requirements.
module xr_route_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b0;
    logic [5:0] pin_i = '0;
    logic       cfg_a_en_i = 1'b0, cfg_b_en_i = 1'b0;
    logic [1:0] cfg_a_sel_i = '0, cfg_b_sel_i = '0;
    logic [3:0] cfg_do_val_i = '0, cfg_do_hiz_i = '0;
    logic [5:0] pin_oe_o, pin_do_o;
    logic [3:0] conn_a_o, conn_b_o;

    int total = 0;
    int bad = 0;
    logic [3:0] m_a = '0, m_b = '0;

    always #10 clk = ~clk;

    xr_route_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pin_i(pin_i),
        .cfg_a_en_i(cfg_a_en_i), .cfg_a_sel_i(cfg_a_sel_i),
        .cfg_b_en_i(cfg_b_en_i), .cfg_b_sel_i(cfg_b_sel_i),
        .cfg_do_val_i(cfg_do_val_i), .cfg_do_hiz_i(cfg_do_hiz_i),
        .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o),
        .conn_a_o(conn_a_o), .conn_b_o(conn_b_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Targets per R1..R5.
    function automatic logic [3:0] onehot(input logic en, input logic [1:0] sel);
        return en ? (4'b0001 << sel) : 4'b0000;
    endfunction

    task automatic targets(output logic [3:0] ta, output logic [3:0] tb);
        logic ae, be;
        logic [1:0] as, bs;
        if (mode_i) begin
            ae = cfg_a_en_i; as = cfg_a_sel_i; be = cfg_b_en_i; bs = cfg_b_sel_i;
        end else begin
            as = pin_i[1:0]; ae = pin_i[2]; bs = pin_i[4:3]; be = pin_i[5];
        end
        ta = onehot(ae, as);
        tb = onehot(be, bs) & ~ta;
    endtask

    // Break-before-make and interlock per R6, R7.
    function automatic logic [3:0] nxt(input logic [3:0] t, input logic [3:0] c,
                                       input logic [3:0] o);
        if (t == c) return c;
        if (c != 0) return 4'b0000;
        if ((t & o) != 0) return 4'b0000;
        return t;
    endfunction

    // Inputs are set at the preceding negedge; check pins, clock, check vectors.
    task automatic step(input string req);
        logic [3:0] ta, tb, na, nb;
        #1;
        chk({req, "/R8/R9 oe"}, {2'b0, pin_oe_o},
            mode_i ? {4'b0, ~cfg_do_hiz_i} : 8'h00);
        chk({req, "/R8/R9 do"}, {2'b0, pin_do_o},
            mode_i ? {4'b0, cfg_do_val_i} : 8'h00);
        targets(ta, tb);
        na = nxt(ta, m_a, m_b);
        nb = nxt(tb, m_b, m_a);
        m_a = na; m_b = nb;
        @(posedge clk); #2;
        chk({req, " conn_a"}, {4'b0, conn_a_o}, {4'b0, m_a});
        chk({req, " conn_b"}, {4'b0, conn_b_o}, {4'b0, m_b});
        @(negedge clk);
    endtask

    function automatic logic [5:0] pins(input logic ae, input logic [1:0] as,
                                        input logic be, input logic [1:0] bs);
        return {be, bs, ae, as};
    endfunction

    initial begin : watchdog
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        pin_i = pins(1'b1, 2'd2, 1'b1, 2'd1);
        repeat (3) @(posedge clk);
        #2;
        chk("R10 reset conn_a", {4'b0, conn_a_o}, 8'h00);
        chk("R10 reset conn_b", {4'b0, conn_b_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // R1/R4/R10: first sampled request closes one cycle later.
        step("R10 first");
        chk("R4 a is SW2", {4'b0, conn_a_o}, 8'h04);
        chk("R1 b is SW1", {4'b0, conn_b_o}, 8'h02);
        // R6: SW2 -> SW3 passes through open.
        pin_i = pins(1'b1, 2'd3, 1'b1, 2'd1);
        step("R6 open");
        chk("R6 a open", {4'b0, conn_a_o}, 8'h00);
        step("R6 close");
        chk("R6 a at SW3", {4'b0, conn_a_o}, 8'h08);
        // R3: disable bank B.
        pin_i = pins(1'b1, 2'd3, 1'b0, 2'd1);
        step("R3 disable");
        chk("R3 b off", {4'b0, conn_b_o}, 8'h00);
        // R5: B alone on SW0, then A disabled but B on A's old choice.
        pin_i = pins(1'b0, 2'd0, 1'b1, 2'd0);
        step("R5 a off");
        step("R5 b on SW0");
        chk("R5 b on SW0 with a disabled", {4'b0, conn_b_o}, 8'h01);
        // R7/R5: A takes SW0 held by B; B opens, A waits one cycle.
        pin_i = pins(1'b1, 2'd0, 1'b1, 2'd0);
        step("R7 wait");
        chk("R7 a waits", {4'b0, conn_a_o}, 8'h00);
        chk("R5 b released", {4'b0, conn_b_o}, 8'h00);
        step("R7 take");
        chk("R7 a on SW0", {4'b0, conn_a_o}, 8'h01);
        chk("R5 b stays off", {4'b0, conn_b_o}, 8'h00);
        // R2: serial mode with pins showing another request.
        mode_i = 1'b1;
        cfg_a_en_i = 1'b1; cfg_a_sel_i = 2'd0;
        cfg_b_en_i = 1'b1; cfg_b_sel_i = 2'd3;
        cfg_do_val_i = 4'b1010; cfg_do_hiz_i = 4'b0110;
        pin_i = pins(1'b1, 2'd1, 1'b1, 2'd2);
        step("R2 serial");
        step("R2 serial hold");
        chk("R2 a from cfg", {4'b0, conn_a_o}, 8'h01);
        chk("R2 b from cfg", {4'b0, conn_b_o}, 8'h08);
        chk("R9 oe", {2'b0, pin_oe_o}, 8'h09);
        pin_i = ~pin_i;
        step("R2 pins ignored");
        chk("R2 pins ignored a", {4'b0, conn_a_o}, 8'h01);
        chk("R2 pins ignored b", {4'b0, conn_b_o}, 8'h08);
        // Random mix, both modes.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            mode_i = r[0];
            pin_i = r[6:1];
            cfg_a_en_i = r[7] | r[8];
            cfg_a_sel_i = r[10:9];
            cfg_b_en_i = r[11] | r[12];
            cfg_b_sel_i = r[14:13];
            cfg_do_val_i = r[18:15];
            cfg_do_hiz_i = r[22:19];
            if (r[23]) pin_i[2] = 1'b1;
            step("R1/R2/R5/R6/R7 random");
        end
        // R10: reset mid-route.
        rst_n = 1'b0;
        @(posedge clk); #2;
        chk("R10 reset again a", {4'b0, conn_a_o}, 8'h00);
        chk("R10 reset again b", {4'b0, conn_b_o}, 8'h00);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule